// File: doc/BRIEF.md
# Serial Counter-Clear Command Receiver

This block listens to a slow, bit-serial management link made of a serial clock and a data line. It watches for a command that asks this chip to clear statistics counters. The serial clock is brought into the system clock domain through synchronizer flops. Each data bit is taken at a rising edge of the serial clock. A frame is accepted only when all of these hold: a run of at least 32 ones, a correct start pattern, the clear opcode, and a device address equal to the strap inputs.

An accepted frame produces a single system-clock pulse on `clear_valid`. Alongside it the block presents a mode flag and a 6-bit index. With the flag set, the index names a port whose counters are all to be cleared. With the flag low, the index names one counter. The counter bank lies outside this block and acts on the pulse.

After every frame, whether complete or abandoned, the first serial clock edge is treated as an idle clock. Only after that edge does the block begin looking for a new run of ones.

Top module: `mclr_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `clear_valid`, `clear_all_port` and `clear_index` read 0.
- R2: A frame is recognised only after at least 32 consecutive 1 bits. A 0 bit seen before the 32nd one restarts the count, so 31 ones followed by a valid frame body produce no pulse.
- R3: Extra 1 bits beyond 32 are accepted before the start field.
- R4: The two bits after the ones must be 0 then 1. Any other start pattern discards the frame without a pulse.
- R5: The next two bits form the opcode. Only 0 then 1 (the clear command) is accepted; any other value discards the frame without a pulse.
- R6: The next two bits, MSB first, form the device address. A pulse is issued only if they equal `phy_addr`; otherwise the frame is read to its end and ignored.
- R7: The bit after the address sets `clear_all_port`. A 1 means clear all counters of the indexed port; a 0 means clear one counter.
- R8: The final 6 bits, MSB first, appear on `clear_index` together with the pulse. `clear_index` and `clear_all_port` keep their values until the next pulse.
- R9: `clear_valid` is high for exactly one `clk` cycle per accepted frame.
- R10: After a frame ends or is discarded, the first rising serial clock edge is not counted as a preamble bit. With no idle clock, a following 32-one preamble is one short and produces no pulse.
- R11: Data is sampled only on rising edges of `ser_clk`. Changes of `ser_data` while `ser_clk` is steady have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_clk | input | 1 | Serial management clock, asynchronous to `clk` |
| ser_data | input | 1 | Serial management data |
| phy_addr | input | 2 | Device address straps |
| clear_valid | output | 1 | One-cycle clear request |
| clear_all_port | output | 1 | 1: clear every counter of port `clear_index`; 0: clear counter `clear_index` |
| clear_index | output | 6 | Port number or counter index |

## Verification
The bench sends a preamble of exactly 31 ones. A decoder that arms one bit early would pulse on that frame. It also sends a frame straight after a previous one with no idle clock. A design that skipped the idle rule would count the full 32 ones and pulse, when no pulse is expected. Single-field corruptions of start, opcode and address each check that the frame is dropped and that the outputs hold their old values. A reset in the middle of a frame, followed by the rest of the frame body, checks that partial state does not survive and trigger a late pulse.

// File: rtl/mclr_pkg.sv
package mclr_pkg;
  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_START = 3'd1,
    ST_OPC   = 3'd2,
    ST_ADDR  = 3'd3,
    ST_TYPE  = 3'd4,
    ST_INDEX = 3'd5,
    ST_GAP   = 3'd6
  } frm_state_t;

  localparam logic [1:0] OPC_CLEAR = 2'b01;
endpackage

// File: rtl/mclr_rstsync.sv
module mclr_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/mclr_edge.sv
module mclr_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_data,
  output logic bit_rise,
  output logic bit_val
);
  logic [STAGES-1:0] ck_q;
  logic [STAGES-1:0] dt_q;
  logic              ck_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q      <= '0;
      dt_q      <= '0;
      ck_prev_q <= 1'b0;
    end else begin
      ck_q      <= {ck_q[STAGES-2:0], ser_clk};
      dt_q      <= {dt_q[STAGES-2:0], ser_data};
      ck_prev_q <= ck_q[STAGES-1];
    end
  end

  assign bit_rise = ck_q[STAGES-1] & ~ck_prev_q;
  assign bit_val  = dt_q[STAGES-1];
endmodule

// File: rtl/mclr_preamble.sv
module mclr_preamble #(
  parameter int PRE_LEN = 32,
  localparam int CW = $clog2(PRE_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          bit_val,
  output logic          armed,
  output logic [CW-1:0] ones_cnt
);
  localparam logic [CW-1:0] FULL = CW'(PRE_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  assign armed = (cnt_q == FULL);

  always_comb begin
    cnt_d = cnt_q;
    if (bit_en) begin
      if (!bit_val)   cnt_d = '0;
      else if (!armed) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (bit_en) cnt_q <= cnt_d;
  end

  assign ones_cnt = cnt_q;
endmodule

// File: rtl/mclr_frame.sv
module mclr_frame
  import mclr_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 2,
  localparam int BCW   = $clog2(IDX_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_rise,
  input  logic              bit_val,
  input  logic              armed,
  input  logic [ADDR_W-1:0] phy_addr,
  output frm_state_t        state,
  output logic              clear_valid,
  output logic              clear_all_port,
  output logic [IDX_W-1:0]  clear_index
);
  localparam logic [BCW-1:0] IDX_LAST  = BCW'(IDX_W - 1);
  localparam logic [BCW-1:0] ADDR_LAST = BCW'(ADDR_W - 1);

  frm_state_t        st_q, st_d;
  logic [BCW-1:0]    bcnt_q, bcnt_d;
  logic [IDX_W-1:0]  sh_q, sh_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              typ_q, typ_d;
  logic              vld_q, vld_d;
  logic              all_q, all_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [IDX_W-1:0]  sh_in;

  assign sh_in = {sh_q[IDX_W-2:0], bit_val};

  always_comb begin
    st_d   = st_q;
    bcnt_d = bcnt_q;
    sh_d   = sh_q;
    addr_d = addr_q;
    typ_d  = typ_q;
    vld_d  = 1'b0;
    all_d  = all_q;
    idx_d  = idx_q;
    if (bit_rise) begin
      unique case (st_q)
        ST_HUNT: begin
          if (!bit_val && armed) st_d = ST_START;
        end
        ST_START: begin
          st_d   = bit_val ? ST_OPC : ST_GAP;
          bcnt_d = '0;
        end
        ST_OPC: begin
          sh_d = sh_in;
          if (bcnt_q == '0) begin
            bcnt_d = BCW'(1);
          end else begin
            st_d   = (sh_in[1:0] == OPC_CLEAR) ? ST_ADDR : ST_GAP;
            bcnt_d = '0;
          end
        end
        ST_ADDR: begin
          sh_d = sh_in;
          if (bcnt_q == ADDR_LAST) begin
            addr_d = sh_in[ADDR_W-1:0];
            st_d   = ST_TYPE;
            bcnt_d = '0;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
        ST_TYPE: begin
          typ_d  = bit_val;
          st_d   = ST_INDEX;
          bcnt_d = '0;
        end
        ST_INDEX: begin
          sh_d = sh_in;
          if (bcnt_q == IDX_LAST) begin
            st_d = ST_GAP;
            if (addr_q == phy_addr) begin
              vld_d = 1'b1;
              all_d = typ_q;
              idx_d = sh_in;
            end
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
        ST_GAP:  st_d = ST_HUNT;
        default: st_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      bcnt_q <= '0;
      sh_q   <= '0;
      addr_q <= '0;
      typ_q  <= 1'b0;
      vld_q  <= 1'b0;
      all_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (bit_rise) begin
        st_q   <= st_d;
        bcnt_q <= bcnt_d;
        sh_q   <= sh_d;
        addr_q <= addr_d;
        typ_q  <= typ_d;
      end
      if (vld_d) begin
        all_q <= all_d;
        idx_q <= idx_d;
      end
    end
  end

  assign state          = st_q;
  assign clear_valid    = vld_q;
  assign clear_all_port = all_q;
  assign clear_index    = idx_q;
endmodule

// File: rtl/mclr_top.sv
module mclr_top
  import mclr_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int IDX_W   = 6,
  parameter int ADDR_W  = 2,
  parameter int SYNC_N  = 2,
  localparam int PCW    = $clog2(PRE_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic [ADDR_W-1:0] phy_addr,
  output logic              clear_valid,
  output logic              clear_all_port,
  output logic [IDX_W-1:0]  clear_index
);
  logic       rst_sync_n;
  logic       ser_rise;
  logic       ser_bit;
  logic       pre_armed;
  logic [PCW-1:0] pre_cnt;
  frm_state_t frm_st;

  mclr_rstsync #(.STAGES(SYNC_N)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mclr_edge #(.STAGES(SYNC_N)) u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .bit_rise (ser_rise),
    .bit_val  (ser_bit)
  );

  mclr_preamble #(.PRE_LEN(PRE_LEN)) u_pre (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bit_en   (ser_rise && (frm_st == ST_HUNT)),
    .bit_val  (ser_bit),
    .armed    (pre_armed),
    .ones_cnt (pre_cnt)
  );

  mclr_frame #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_frm (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .bit_rise       (ser_rise),
    .bit_val        (ser_bit),
    .armed          (pre_armed),
    .phy_addr       (phy_addr),
    .state          (frm_st),
    .clear_valid    (clear_valid),
    .clear_all_port (clear_all_port),
    .clear_index    (clear_index)
  );
endmodule

// File: rtl/mclr_chk.sv
module mclr_chk
  import mclr_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int IDX_W   = 6,
  localparam int PCW    = $clog2(PRE_LEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_valid,
  input logic             clear_all_port,
  input logic [IDX_W-1:0] clear_index,
  input frm_state_t       frm_st,
  input logic [PCW-1:0]   pre_cnt,
  input logic             ser_rise
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clear_valid |=> !clear_valid); // R9

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_valid |-> ($stable(clear_index) && $stable(clear_all_port))); // R8

  AST_PULSE_FROM_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    clear_valid |-> ($past(frm_st) == ST_INDEX)); // R6

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= PCW'(PRE_LEN)); // R2

  AST_GAP_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_st == ST_GAP && ser_rise) |=> (frm_st == ST_HUNT && pre_cnt == '0)); // R10
endmodule

bind mclr_top mclr_chk #(.PRE_LEN(PRE_LEN), .IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .clear_valid    (clear_valid),
  .clear_all_port (clear_all_port),
  .clear_index    (clear_index),
  .frm_st         (frm_st),
  .pre_cnt        (pre_cnt),
  .ser_rise       (ser_rise)
);

// File: tb/sim_mclr_top.sv
`timescale 1ns/1ps
module sim_mclr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic [1:0] phy_addr = 2'b10;
  logic       clear_valid;
  logic       clear_all_port;
  logic [5:0] clear_index;

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;
  logic       got_all = 1'b0;
  logic [5:0] got_idx = '0;

  always #10 clk = ~clk;

  mclr_top u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .phy_addr(phy_addr), .clear_valid(clear_valid),
    .clear_all_port(clear_all_port), .clear_index(clear_index)
  );

  always @(negedge clk) begin
    if (clear_valid) begin
      pulses  = pulses + 1;
      got_all = clear_all_port;
      got_idx = clear_index;
    end
  end

  // {pre[19:14], start[13:12], opc[11:10], addr[9:8], typ[7], idx[6:1], exp[0]}
  localparam logic [19:0] VEC [8] = '{
    {6'd32, 2'b01, 2'b01, 2'b10, 1'b1, 6'h05, 1'b1},  // R7 all-port
    {6'd32, 2'b01, 2'b01, 2'b10, 1'b0, 6'h2A, 1'b1},  // R7 single counter
    {6'd40, 2'b01, 2'b01, 2'b10, 1'b1, 6'h3F, 1'b1},  // R3 long preamble
    {6'd31, 2'b01, 2'b01, 2'b10, 1'b1, 6'h11, 1'b0},  // R2 one short
    {6'd32, 2'b00, 2'b01, 2'b10, 1'b1, 6'h12, 1'b0},  // R4 bad start
    {6'd32, 2'b01, 2'b10, 2'b10, 1'b1, 6'h13, 1'b0},  // R5 bad opcode
    {6'd32, 2'b01, 2'b01, 2'b01, 1'b1, 6'h14, 1'b0},  // R6 wrong address
    {6'd32, 2'b01, 2'b01, 2'b10, 1'b0, 6'h00, 1'b1}   // R8 zero index
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); ser_data = b; ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic send_body(input logic [1:0] st, input logic [1:0] op,
                           input logic [1:0] ad, input logic ty, input logic [5:0] ix);
    send_bit(st[1]); send_bit(st[0]);
    send_bit(op[1]); send_bit(op[0]);
    send_bit(ad[1]); send_bit(ad[0]);
    send_bit(ty);
    for (int i = 5; i >= 0; i--) send_bit(ix[i]);
  endtask

  task automatic idle2;
    send_bit(1'b0); send_bit(1'b0);
    repeat (20) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    check(clear_valid == 1'b0 && clear_index == 6'd0 && clear_all_port == 1'b0,
          "R1 in reset", clear_index, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(clear_valid == 1'b0 && clear_index == 6'd0, "R1 after reset", clear_index, 0);
    send_bit(1'b0);

    for (int v = 0; v < 8; v++) begin
      logic [19:0] w;
      logic [5:0]  oidx;
      logic        oall;
      w = VEC[v];
      oidx = got_idx; oall = got_all;
      p0 = pulses;
      send_ones(int'(w[19:14]));
      send_body(w[13:12], w[11:10], w[9:8], w[7], w[6:1]);
      idle2();
      check(pulses - p0 == int'(w[0]), $sformatf("R9 vector %0d pulse count", v),
            pulses - p0, int'(w[0]));
      if (w[0]) begin
        check(got_all == w[7], $sformatf("R7 vector %0d mode", v), got_all, w[7]);
        check(got_idx == w[6:1], $sformatf("R8 vector %0d index", v), got_idx, w[6:1]);
      end else begin
        check(clear_index == oidx && clear_all_port == oall,
              $sformatf("R8 vector %0d outputs held", v), clear_index, oidx);
      end
    end

    // R10: frame directly after a frame, no idle clock -> preamble one short
    p0 = pulses;
    send_ones(32); send_body(2'b01, 2'b01, 2'b10, 1'b1, 6'h21);
    send_ones(32); send_body(2'b01, 2'b01, 2'b10, 1'b1, 6'h22);
    repeat (20) @(negedge clk);
    check(pulses - p0 == 1, "R10 no idle clock", pulses - p0, 1);
    check(got_idx == 6'h21, "R10 surviving index", got_idx, 6'h21);
    // R10: same with one idle clock in between -> both accepted
    p0 = pulses;
    send_bit(1'b1);
    send_ones(32); send_body(2'b01, 2'b01, 2'b10, 1'b0, 6'h23);
    send_bit(1'b0);
    send_ones(32); send_body(2'b01, 2'b01, 2'b10, 1'b0, 6'h24);
    idle2();
    check(pulses - p0 == 2, "R10 with idle clock", pulses - p0, 2);
    check(got_idx == 6'h24, "R10 second index", got_idx, 6'h24);

    // R2: a 0 inside the ones restarts the count
    p0 = pulses;
    send_ones(20); send_bit(1'b0); send_ones(12);
    send_body(2'b01, 2'b01, 2'b10, 1'b1, 6'h30);
    idle2();
    check(pulses - p0 == 0, "R2 broken preamble", pulses - p0, 0);

    // R11: data wiggles while ser_clk is steady
    p0 = pulses;
    send_ones(32);
    @(negedge clk); ser_data = 1'b1;
    repeat (4) @(negedge clk); ser_data = 1'b0;
    repeat (4) @(negedge clk); ser_data = 1'b1;
    repeat (4) @(negedge clk);
    send_body(2'b01, 2'b01, 2'b10, 1'b1, 6'h0C);
    idle2();
    check(pulses - p0 == 1 && got_idx == 6'h0C, "R11 steady clock", got_idx, 6'h0C);

    // R1: reset in mid-frame leaves no partial state
    p0 = pulses;
    send_ones(32); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    do_reset();
    check(clear_index == 6'd0 && clear_all_port == 1'b0, "R1 mid-frame reset",
          clear_index, 0);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    idle2();
    check(pulses - p0 == 0, "R1 no late pulse", pulses - p0, 0);

    // R6: new strap value
    phy_addr = 2'b01;
    p0 = pulses;
    send_ones(32); send_body(2'b01, 2'b01, 2'b01, 1'b1, 6'h1B);
    idle2();
    check(pulses - p0 == 1 && got_idx == 6'h1B, "R6 strap 01 match", got_idx, 6'h1B);
    p0 = pulses;
    send_ones(32); send_body(2'b01, 2'b01, 2'b10, 1'b1, 6'h1C);
    idle2();
    check(pulses - p0 == 0, "R6 strap 01 mismatch", pulses - p0, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule